// File: doc/BRIEF.md
# E1 Serial Channel-Signaling Merger

This block sits in the transmit path of an E1 system interface. It carries a 2.048 Mbit/s bit-serial stream of 32 eight-bit time slots per frame. It merges channel-associated signaling from a separate serial signaling input into that stream. The system data stream and the signaling input share one transmit clock. A sync pulse marks the first bit of a 16-frame multiframe. Two counters follow the stream position: a frame counter from 0 to 15 and a slot counter from 0 to 31. The sync pulse restarts both.

The signaling input is read only during the last frame (frame 15) of each multiframe. In that frame the block keeps bits 5 to 8 of every channel slot and the whole of slot 16. Bits are numbered in transmission order, so bit 1 is sent first. At the start of the next multiframe the captured set becomes the active set. It is then sent in slot 16 of each frame of that multiframe, aligned to the multiframe boundary. Slot 0 always carries the frame alignment word taken live from the signaling input. An internal signaling source can take over slot 16. When signaling is disabled, the system data passes through untouched. The output is registered, with one clock of latency.

Top module: `e1cas_merge`

## Requirements
- R1: Once reset is released, `tx_data_o` is 0 until the first clock edge that follows the release.
- R2: When `sig_en_i` is 0, `tx_data_o` equals `sys_data_i` from one clock earlier, in every slot.
- R3: When `sig_en_i` is 1, slots 1 to 15 and 17 to 31 pass `sys_data_i` with one clock of latency.
- R4: When `sig_en_i` is 1, slot 0 carries `sig_data_i` from one clock earlier, and `sys_data_i` is not used there.
- R5: When `sig_en_i` is 1 and `int_en_i` is 0, slot 16 of frame 0 carries the eight bits of slot 16 that `sig_data_i` carried in frame 15 of the previous multiframe. The bits keep their order, bit 1 first.
- R6: Slot 16 of frame k (1 to 15) carries bits 5 to 8 of channel k in its bit positions 1 to 4, then bits 5 to 8 of channel k+16 in positions 5 to 8. These are taken from frame 15 of the previous multiframe. Bits 1 to 4 of the channel slots are discarded.
- R7: `sig_data_i` is ignored in frames 0 to 14. The captured signaling state changes only in frame 15.
- R8: When `sig_en_i` and `int_en_i` are both 1, slot 16 carries `int_data_i` from one clock earlier.
- R9: A high `sync_i` marks the current bit as bit 1 of slot 0 of frame 0, whatever the counters held before. The position then advances by one bit per clock, 8 bits per slot, 32 slots per frame and 16 frames per multiframe.
- R10: Captured signaling becomes the active set on the first bit of frame 0 of the following multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit system bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Multiframe start pulse, high on bit 1 of slot 0 of frame 0 |
| sys_data_i | input | 1 | Serial system data stream |
| sig_data_i | input | 1 | Serial signaling input |
| sig_en_i | input | 1 | 1: merge signaling; 0: pass-through |
| int_en_i | input | 1 | 1: internal source overrides slot 16 |
| int_data_i | input | 1 | Serial bits from the internal signaling source |
| tx_data_o | output | 1 | Merged serial output, one clock after the input |

## Verification
The hardest case to reach from the ports is a correct slot 16 in a later multiframe. The capture and the use of the signaling are a whole multiframe (4096 clocks) apart. Every channel nibble must also land in its own frame and half-byte. The stimulus therefore runs several complete multiframes of random system, signaling and internal bits. The bench model builds its own capture store from the frame-15 traffic and checks each slot 16 bit in the next multiframe. A sync pulse placed in the middle of a multiframe also shows that realignment restarts the frame numbering and the handover of the captured set.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  localparam int unsigned SLOT_BITS = 8;
  localparam int unsigned NIB_BITS  = 4;

  typedef enum logic [1:0] {
    SC_FAS  = 2'd0,
    SC_SIG  = 2'd1,
    SC_DATA = 2'd2
  } slot_kind_e;

  // Kind of slot: alignment word, signaling slot or payload.
  function automatic slot_kind_e slot_kind(input int unsigned slot,
                                           input int unsigned sig_slot);
    if (slot == 0)             return SC_FAS;
    else if (slot == sig_slot) return SC_SIG;
    else                       return SC_DATA;
  endfunction

  // Bit 1 (index 0) is sent first, so it is the MSB of the byte.
  function automatic logic pick_bit(input logic [SLOT_BITS-1:0] b,
                                    input logic [2:0] idx);
    return b[3'(SLOT_BITS-1) - idx];
  endfunction

  // Signaling byte for frame k: channel k high nibble, channel k+half low.
  function automatic logic [SLOT_BITS-1:0] pair_byte(input logic [NIB_BITS-1:0] hi,
                                                     input logic [NIB_BITS-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/e1cas_counter.sv
module e1cas_counter #(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned FRAMES = 16,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic [2:0]    bit_o,
  output logic [SW-1:0] slot_o,
  output logic [FW-1:0] frame_o
);
  logic [2:0]    bit_q;
  logic [SW-1:0] slot_q;
  logic [FW-1:0] frame_q;

  // Sync forces the current bit to the multiframe start.
  always_comb begin
    if (sync_i) begin
      bit_o   = '0;
      slot_o  = '0;
      frame_o = '0;
    end else begin
      bit_o   = bit_q;
      slot_o  = slot_q;
      frame_o = frame_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      slot_q  <= '0;
      frame_q <= '0;
    end else begin
      bit_q   <= bit_o + 3'd1;
      slot_q  <= slot_o;
      frame_q <= frame_o;
      if (bit_o == 3'd7) begin
        if (slot_o == SW'(SLOTS-1)) begin
          slot_q  <= '0;
          frame_q <= (frame_o == FW'(FRAMES-1)) ? '0 : frame_o + FW'(1);
        end else begin
          slot_q <= slot_o + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/e1cas_capture.sv
module e1cas_capture
  import e1cas_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned FRAMES = 16,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned FW = $clog2(FRAMES),
  localparam int unsigned SIG_SLOT = SLOTS / 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            sig_i,
  input  logic [2:0]                      bit_i,
  input  logic [SW-1:0]                   slot_i,
  input  logic [FW-1:0]                   frame_i,
  output logic                            cap_evt_o,
  output logic                            xfer_evt_o,
  output logic [SLOTS-1:0][NIB_BITS-1:0]  stg_nib_o,
  output logic [SLOT_BITS-1:0]            stg_sig_o,
  output logic [SLOTS-1:0][NIB_BITS-1:0]  act_nib_o,
  output logic [SLOT_BITS-1:0]            act_sig_o
);
  logic [SLOT_BITS-2:0] shift_q;
  logic [SLOT_BITS-1:0] byte_now;

  assign byte_now   = {shift_q, sig_i};
  assign cap_evt_o  = (frame_i == FW'(FRAMES-1)) && (bit_i == 3'd7) && (slot_i != '0);
  assign xfer_evt_o = (frame_i == '0) && (slot_i == '0) && (bit_i == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= byte_now[SLOT_BITS-2:0];
  end

  // Staging store, written only in the last frame of a multiframe.
  for (genvar s = 1; s < SLOTS; s++) begin : g_stage
    if (s == SIG_SLOT) begin : g_sig
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_sig_o <= '0;
        else if (cap_evt_o && slot_i == SW'(s)) stg_sig_o <= byte_now;
      end
      assign stg_nib_o[s] = '0;
    end else begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_nib_o[s] <= '0;
        else if (cap_evt_o && slot_i == SW'(s)) stg_nib_o[s] <= byte_now[NIB_BITS-1:0];
      end
    end
  end
  assign stg_nib_o[0] = '0;

  // Active set, loaded at the multiframe boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_nib_o <= '0;
      act_sig_o <= '0;
    end else if (xfer_evt_o) begin
      act_nib_o <= stg_nib_o;
      act_sig_o <= stg_sig_o;
    end
  end
endmodule

// File: rtl/e1cas_merge.sv
module e1cas_merge
  import e1cas_pkg::*;
#(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned FRAMES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic sys_data_i,
  input  logic sig_data_i,
  input  logic sig_en_i,
  input  logic int_en_i,
  input  logic int_data_i,
  output logic tx_data_o
);
  localparam int unsigned SW = $clog2(SLOTS);
  localparam int unsigned FW = $clog2(FRAMES);
  localparam int unsigned SIG_SLOT = SLOTS / 2;

  logic [2:0]    cur_bit;
  logic [SW-1:0] cur_slot;
  logic [FW-1:0] cur_frame;
  logic          cap_evt, xfer_evt;
  logic [SLOTS-1:0][NIB_BITS-1:0] stg_nib, act_nib;
  logic [SLOT_BITS-1:0] stg_sig, act_sig;
  logic [SLOT_BITS-1:0] sig_byte;
  logic          slot_bit, next_tx;
  slot_kind_e    kind;

  e1cas_counter #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
    .bit_o(cur_bit), .slot_o(cur_slot), .frame_o(cur_frame)
  );

  e1cas_capture #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_cap (
    .clk(clk), .rst_n(rst_n), .sig_i(sig_data_i),
    .bit_i(cur_bit), .slot_i(cur_slot), .frame_i(cur_frame),
    .cap_evt_o(cap_evt), .xfer_evt_o(xfer_evt),
    .stg_nib_o(stg_nib), .stg_sig_o(stg_sig),
    .act_nib_o(act_nib), .act_sig_o(act_sig)
  );

  assign kind = slot_kind(int'(cur_slot), SIG_SLOT);
  assign sig_byte = (cur_frame == '0) ? act_sig
                  : pair_byte(act_nib[cur_frame],
                              act_nib[SW'(cur_frame) + SW'(SIG_SLOT)]);
  assign slot_bit = pick_bit(sig_byte, cur_bit);

  always_comb begin
    next_tx = sys_data_i;
    if (sig_en_i) begin
      unique case (kind)
        SC_FAS:  next_tx = sig_data_i;
        SC_SIG:  next_tx = int_en_i ? int_data_i : slot_bit;
        default: next_tx = sys_data_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_data_o <= 1'b0;
    else        tx_data_o <= next_tx;
  end
endmodule

// File: rtl/e1cas_checks.sv
module e1cas_checks #(
  parameter int unsigned SLOTS  = 32,
  parameter int unsigned FRAMES = 16,
  localparam int unsigned SW = $clog2(SLOTS),
  localparam int unsigned FW = $clog2(FRAMES)
) (
  input logic clk,
  input logic rst_n,
  input logic sync_i,
  input logic sys_data_i,
  input logic sig_data_i,
  input logic sig_en_i,
  input logic int_en_i,
  input logic int_data_i,
  input logic tx_data_o,
  input logic [2:0] cur_bit,
  input logic [SW-1:0] cur_slot,
  input logic [FW-1:0] cur_frame,
  input logic cap_evt,
  input logic xfer_evt,
  input logic [SLOTS*4-1:0] stg_nib,
  input logic [7:0] stg_sig
);
  localparam int unsigned SIG_SLOT = SLOTS / 2;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tx_data_o); // R1

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_en_i |=> tx_data_o == $past(sys_data_i)); // R2

  AST_PAYLOAD_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en_i && cur_slot != '0 && cur_slot != SW'(SIG_SLOT))
      |=> tx_data_o == $past(sys_data_i)); // R3

  AST_FAS_FROM_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en_i && cur_slot == '0) |=> tx_data_o == $past(sig_data_i)); // R4

  AST_INT_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en_i && int_en_i && cur_slot == SW'(SIG_SLOT))
      |=> tx_data_o == $past(int_data_i)); // R8

  AST_CAPTURE_LAST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> cur_frame == FW'(FRAMES-1)); // R7

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(stg_nib) && $stable(stg_sig)); // R7

  AST_SYNC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !cap_evt) |=> (sync_i || (cur_bit == 3'd1 && cur_slot == '0 && cur_frame == '0))); // R9

  AST_XFER_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |-> (cur_bit == 3'd0 && cur_slot == '0 && cur_frame == '0)); // R10
endmodule

bind e1cas_merge e1cas_checks #(.SLOTS(SLOTS), .FRAMES(FRAMES)) u_checks (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sys_data_i(sys_data_i),
  .sig_data_i(sig_data_i), .sig_en_i(sig_en_i), .int_en_i(int_en_i),
  .int_data_i(int_data_i), .tx_data_o(tx_data_o),
  .cur_bit(cur_bit), .cur_slot(cur_slot), .cur_frame(cur_frame),
  .cap_evt(cap_evt), .xfer_evt(xfer_evt),
  .stg_nib(stg_nib), .stg_sig(stg_sig)
);

// File: tb/tb_e1cas_merge.sv
`timescale 1ns/1ps
module tb_e1cas_merge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_i = 1'b0, sys_data_i = 1'b0, sig_data_i = 1'b0;
  logic sig_en_i = 1'b0, int_en_i = 1'b0, int_data_i = 1'b0;
  logic tx_data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  e1cas_merge dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .sys_data_i(sys_data_i),
    .sig_data_i(sig_data_i), .sig_en_i(sig_en_i), .int_en_i(int_en_i),
    .int_data_i(int_data_i), .tx_data_o(tx_data_o)
  );

  // Bench model of the stream position and signaling stores.
  int mb = 0, ms = 0, mf = 0;
  logic [7:0] m_byte = '0;
  logic [3:0] m_stg [32];
  logic [3:0] m_act [32];
  logic [7:0] m_stg16 = '0, m_act16 = '0;
  logic exp_tx = 1'b0;
  bit   pending = 0;
  string exp_req = "";

  function automatic string req_for(input int s, input bit en, input bit ie, input int f);
    if (!en) return "R2";
    if (s == 0) return "R4";
    if (s != 16) return "R3";
    if (ie) return "R8";
    return (f == 0) ? "R5/R10" : "R6/R7";
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tx_data_o=%0b expected %0b (frame %0d slot %0d)", req, act, exp, mf, ms);
    end
  endtask

  // One bit period: check the previous bit, drive a new one.
  task automatic step(input bit do_sync);
    logic sy, sg, it;
    @(negedge clk);
    if (pending) check(tx_data_o, exp_tx, exp_req);
    sy = $urandom_range(0, 1);
    sg = $urandom_range(0, 1);
    it = $urandom_range(0, 1);
    sync_i = do_sync; sys_data_i = sy; sig_data_i = sg; int_data_i = it;
    if (do_sync) begin mb = 0; ms = 0; mf = 0; end
    if (mb == 0 && ms == 0 && mf == 0) begin
      foreach (m_act[i]) m_act[i] = m_stg[i];
      m_act16 = m_stg16;
    end
    exp_req = req_for(ms, sig_en_i, int_en_i, mf);
    if (!sig_en_i)     exp_tx = sy;
    else if (ms == 0)  exp_tx = sg;
    else if (ms != 16) exp_tx = sy;
    else if (int_en_i) exp_tx = it;
    else if (mf == 0)  exp_tx = m_act16[7-mb];
    else if (mb < 4)   exp_tx = m_act[mf][3-mb];
    else               exp_tx = m_act[mf+16][7-mb];
    pending = 1;
    m_byte = {m_byte[6:0], sg};
    if (mf == 15 && mb == 7 && ms != 0) begin
      if (ms == 16) m_stg16 = m_byte;
      else          m_stg[ms] = m_byte[3:0];
    end
    mb++;
    if (mb == 8) begin
      mb = 0; ms++;
      if (ms == 32) begin ms = 0; mf = (mf + 1) % 16; end
    end
  endtask

  task automatic run_mf(input int n_bits, input bit first_sync);
    for (int i = 0; i < n_bits; i++) step(first_sync && i == 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none
    void'($urandom(32'h5A17));
    foreach (m_stg[i]) begin m_stg[i] = '0; m_act[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(tx_data_o, 1'b0, "R1");  // reset state
    sig_en_i = 1'b1;
    run_mf(4096, 1);               // capture first set
    run_mf(4096, 1);               // send it, capture next
    run_mf(4096, 0);               // free-running counters
    int_en_i = 1'b1;
    run_mf(4096, 1);               // internal override
    int_en_i = 1'b0;
    run_mf(3 * 256 + 37, 1);       // partial multiframe
    run_mf(4096, 1);               // early resync R9
    run_mf(4096, 1);
    sig_en_i = 1'b0;
    run_mf(2048, 0);               // pass-through
    sig_en_i = 1'b1;
    run_mf(4096, 1);
    @(negedge clk);
    if (pending) check(tx_data_o, exp_tx, exp_req);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule